// File: doc/BRIEF.md
# Selectable Periodic Interrupt Generator

This block raises a sticky periodic flag at one of six rates and drives an interrupt line from it. It counts pulses of a 256 Hz base tick from the clock prescaler in one free-running divider, and a 3-bit rate code chooses which divider tap sets the flag. Software programs the rate code and clears the flag through the upper nibble of one byte-wide control register. Writing a 1 to the flag position leaves the flag alone, so a write that only changes the rate does not lose a pending event.

The divider never restarts when the rate code changes. The new rate takes effect at the next matching tap edge of the running count.

Top module: `periodic_irq_gen`

## Requirements
- R1: After reset the flag is 0, the rate code is 0, the read data is 0 and `irq` is low.
- R2: The control nibble is bit 3 = flag and bits 2..0 = rate code. A write with `ctl_cs`=1 and `ctl_we`=1 stores the rate code, and a read with `ctl_cs`=1 returns both fields. When `ctl_cs`=0 the read data is 0.
- R3: Writing 0 to the flag bit clears the flag in the cycle after the write.
- R4: Writing 1 to the flag bit has no effect on the flag.
- R5: Rate codes 0 and 7 never set the flag, whatever ticks arrive.
- R6: Let n be the number of `tick` pulses seen since reset before the current pulse. The flag is set on a pulse when n mod P equals P-1. P is 1, 4, 16, 64, 128 and 256 for codes 1 to 6, which is 256, 64, 16, 4, 2 and 1 Hz. The flag is visible in the cycle after the pulse.
- R7: A change of rate code does not restart the divider, so R6 holds with n counted across all code changes.
- R8: `irq` is high exactly when the flag is set and the rate code is 1 to 6.
- R9: When a hardware set and a software clear fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse at 256 Hz from the prescaler |
| ctl_cs | input | 1 | Control register select |
| ctl_we | input | 1 | Write strobe, qualified by `ctl_cs` |
| ctl_wdata | input | 4 | Upper nibble of the control byte: flag, rate code |
| ctl_rdata | output | 4 | Upper nibble read back: flag, rate code |
| irq | output | 1 | Periodic interrupt request |

## Verification
The assertions assume that `tick` is a single-cycle pulse and that a write is a single-cycle strobe with stable data. The checks on clear and hold also assume that a flag write carrying a 0 only matters in a cycle without a tick. The bench applies every input at the falling clock edge and holds it for exactly one rising edge. It pulses `tick` only from its own step task and keeps its own running tick count. It issues writes alongside ticks only in the priority scenario, where both are meant to coincide.

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen #(
  parameter int TICK_HZ = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       ctl_cs,
  input  logic       ctl_we,
  input  logic [3:0] ctl_wdata,
  output logic [3:0] ctl_rdata,
  output logic       irq
);
  localparam int DIV_W = $clog2(TICK_HZ);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] tap_mask;
  logic [2:0]       rate_q;
  logic             flag_q;
  logic             rate_on;
  logic             wr;
  logic             hw_set;
  logic             sw_clr;

  assign wr      = ctl_cs & ctl_we;
  assign rate_on = (rate_q != 3'd0) && (rate_q != 3'd7);

  always_comb begin
    case (rate_q)
      3'd1:    tap_mask = '0;
      3'd2:    tap_mask = DIV_W'(3);
      3'd3:    tap_mask = DIV_W'(15);
      3'd4:    tap_mask = DIV_W'(63);
      3'd5:    tap_mask = DIV_W'(127);
      default: tap_mask = '1;
    endcase
  end

  assign hw_set = tick & rate_on & ((div_q & tap_mask) == tap_mask);
  assign sw_clr = wr & ~ctl_wdata[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      rate_q <= 3'd0;
      flag_q <= 1'b0;
    end else begin
      if (tick) div_q <= div_q + 1'b1;
      if (wr) rate_q <= ctl_wdata[2:0];
      if (hw_set) flag_q <= 1'b1;
      else if (sw_clr) flag_q <= 1'b0;
    end
  end

  assign ctl_rdata = ctl_cs ? {flag_q, rate_q} : 4'h0;
  assign irq       = flag_q & rate_on;

  AST_SET_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick)); // R6
  AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !rate_on) |=> !flag_q); // R5
  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !ctl_wdata[3] && !tick) |=> !flag_q); // R3
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && (!wr || ctl_wdata[3])) |=> $stable(flag_q)); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr && hw_set) |=> flag_q); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !rate_on |-> !irq); // R8
endmodule

// File: tb/test_periodic_irq_gen.sv
module test_periodic_irq_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       ctl_cs = 1'b0;
  logic       ctl_we = 1'b0;
  logic [3:0] ctl_wdata = 4'h0;
  logic [3:0] ctl_rdata;
  logic       irq;

  int checks = 0;
  int fails = 0;
  int nticks = 0;

  periodic_irq_gen i_periodic_irq_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_cs(ctl_cs), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic w, input logic [3:0] d);
    @(negedge clk);
    tick = t; ctl_cs = w; ctl_we = w; ctl_wdata = d;
    @(posedge clk);
    if (t) nticks++;
    @(negedge clk);
    tick = 1'b0; ctl_cs = 1'b1; ctl_we = 1'b0; ctl_wdata = 4'h0;
    #1;
  endtask

  function automatic int period_of(input int code);
    case (code)
      1: return 1;
      2: return 4;
      3: return 16;
      4: return 64;
      5: return 128;
      6: return 256;
      default: return 0;
    endcase
  endfunction

  task automatic t_reset;
    @(negedge clk); ctl_cs = 1'b1; #1;
    check("R1 rdata", ctl_rdata, 4'h0);
    check("R1 irq", {3'b0, irq}, 4'h0);
    ctl_cs = 1'b0; #1;
    check("R2 deselect", ctl_rdata, 4'h0);
  endtask

  task automatic t_readback;
    step(1'b0, 1'b1, 4'b0011);
    check("R2 readback", ctl_rdata, 4'b0011);
    step(1'b0, 1'b1, 4'b0000);
    check("R2 readback zero", ctl_rdata, 4'b0000);
  endtask

  task automatic t_off(input logic [2:0] code);
    step(1'b0, 1'b1, {1'b0, code});
    for (int i = 0; i < 300; i++) step(1'b1, 1'b0, 4'h0);
    check("R5 no set", ctl_rdata, {1'b0, code});
    check("R5 irq", {3'b0, irq}, 4'h0);
  endtask

  task automatic t_rate(input int code);
    int p = period_of(code);
    logic exp;
    step(1'b0, 1'b1, {1'b0, 3'(code)});
    for (int i = 0; i < 2 * p + 3; i++) begin
      exp = ((nticks % p) == p - 1);
      step(1'b1, 1'b0, 4'h0);
      check("R6 R7 rate", ctl_rdata, {exp, 3'(code)});
      check("R8 irq", {3'b0, irq}, {3'b0, exp});
      if (exp) begin
        step(1'b0, 1'b1, {1'b0, 3'(code)});
        check("R3 clear", ctl_rdata, {1'b0, 3'(code)});
      end
    end
  endtask

  task automatic t_keep_and_gate;
    step(1'b0, 1'b1, 4'b0001);
    step(1'b1, 1'b0, 4'h0);
    check("R6 code1 set", ctl_rdata, 4'b1001);
    step(1'b0, 1'b1, 4'b1001);
    check("R4 write one keeps", ctl_rdata, 4'b1001);
    step(1'b0, 1'b1, 4'b1000);
    check("R8 flag kept code0", ctl_rdata, 4'b1000);
    check("R8 irq low code0", {3'b0, irq}, 4'h0);
    step(1'b0, 1'b1, 4'b1111);
    check("R8 irq low code7", {3'b0, irq}, 4'h0);
    step(1'b0, 1'b1, 4'b1001);
    check("R8 irq high", {3'b0, irq}, 4'h1);
  endtask

  task automatic t_priority;
    step(1'b1, 1'b1, 4'b0001);
    check("R9 set beats clear", ctl_rdata, 4'b1001);
    step(1'b0, 1'b1, 4'b0000);
    check("R3 clear final", ctl_rdata, 4'b0000);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    t_readback;
    t_off(3'd0);
    t_off(3'd7);
    for (int c = 1; c <= 6; c++) t_rate(c);
    t_rate(3);
    t_keep_and_gate;
    t_priority;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule